// File: doc/BRIEF.md
# Serial Register Access Command Engine

This block is the peripheral-side command handler that sits behind a full-duplex serial link once the bit stream has been framed into 32-bit words. Each word the host sends arrives as a one-cycle `in_valid` pulse with `in_word`. The block answers every accepted word with exactly one outgoing word, which the serializer picks up on `out_valid`. The first word of a command is a header. The block decodes the header, checks its parity and then runs a burst of one to 128 register reads or writes on a simple internal register port. The address either steps up by one after each access or stays fixed.

The returned stream runs one word behind the incoming stream. The serializer supplies the don't-care word for the first slot. The block then returns the header echo, then the echo of each write word or the value of each read, then a zero for the closing word of the command. A header with a parity error starts no register access. Its echo carries the bad-header flag, and the rest of that select period is answered with zeros. Raising chip select ends any command and makes the next word a header again.

Top module: `sra_cmd_engine`

## Requirements
- R1: The header fields are decoded as follows. Bit 31 = 0 marks a command. Bit 29 = 1 selects write and 0 selects read. Bit 28 = 1 holds the address. Bits 27:24 drive `reg_sel`. Bits 23:8 give the first `reg_addr`. Bits 7:1 give the access count minus one. The XOR of all 32 bits must be 1 (odd parity).
- R2: A count field of 0 performs exactly one access, and a count field of 127 performs exactly 128 accesses.
- R3: With bit 28 clear, the address rises by one after every access, wrapping at 16 bits. With bit 28 set, every access in the burst uses the start address.
- R4: The echo of a command header is the received header with bit 30 replaced by the parity-error flag (1 = bad) and bit 0 recomputed, so that the echo has odd parity. Whatever bit 30 the host sent is ignored.
- R5: In a write burst, the words after the header are written in order on `reg_wdata` with `reg_we` and echoed unchanged. The single word after the last data word causes no access and is answered with zero.
- R6: In a read burst, the incoming words after the header are ignored and one read with `reg_re` is issued per word. Each returned word is `reg_rdata` when `reg_hit` is high in the cycle after `reg_re`, and zero when it is low. The closing word is answered with zero.
- R7: A command header with bad parity causes no register access. Every further word until chip select rises is answered with zero.
- R8: A header with bit 31 = 1 is not a command. It is answered with zero, causes no access, and every further word until chip select rises is answered with zero.
- R9: While `cs_n` is high, `in_valid` is ignored. A high `cs_n` ends any burst, so the next accepted word is decoded as a header.
- R10: `out_valid` pulses exactly two cycles after each accepted word and at no other time, and `out_word` changes only together with `out_valid`. After reset both are 0, and `reg_we` and `reg_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select from the link, active low |
| in_valid | input | 1 | One-cycle pulse: a received word is on `in_word` |
| in_word | input | 32 | Received word |
| out_valid | output | 1 | One-cycle pulse: `out_word` holds the next word to send |
| out_word | output | 32 | Word to send |
| reg_sel | output | 4 | Register map select |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 32 | Register write data |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_rdata | input | 32 | Read data, valid the cycle after `reg_re` |
| reg_hit | input | 1 | Address is implemented, valid with `reg_rdata` |

## Verification
The delicate overlap is a burst ending in the same cycle that new input arrives. In that cycle a word is presented while chip select is already high, so the abort and a register access compete. The bench cuts a four-register write short after two data words. It then pulses `in_valid` with chip select released and reads the range back. It judges the result by three things: no output word appears for the ignored pulse, the access counter stops at two, and only the first two registers changed. The same overlap appears when a read strobe and the registration of the previous word's output share a cycle. Back-to-back reads across implemented and unimplemented addresses show whether each returned value lands in its own slot.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 4;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 7;
  localparam int LEFT_W = CNT_W + 1;

  // header layout; the field order is fixed by the link protocol
  typedef struct packed {
    logic              ctl_n;
    logic              hdr_bad;
    logic              wr;
    logic              hold;
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  cnt;
    logic              par;
  } sra_hdr_t;

  typedef enum logic [1:0] {PH_HDR, PH_BURST, PH_DROP} sra_phase_e;
  typedef enum logic [1:0] {OK_ZERO, OK_WORD, OK_READ} sra_okind_e;
endpackage

// File: rtl/sra_hdr_dec.sv
module sra_hdr_dec
  import sra_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output sra_hdr_t          hdr_o,
  output logic              par_ok_o,
  output logic [WORD_W-1:0] echo_o
);
  logic [WORD_W-1:0] echo_base;

  always_comb begin
    hdr_o     = sra_hdr_t'(word_i);
    par_ok_o  = ^word_i;
    echo_base = word_i;
    echo_base[30] = ~(^word_i);
    echo_base[0]  = 1'b0;
  end

  // bit 0 chosen so that the echoed word has odd parity
  assign echo_o = {echo_base[WORD_W-1:1], ~(^echo_base)};
endmodule

// File: rtl/sra_burst_ctl.sv
module sra_burst_ctl
  import sra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_word_i,
  input  sra_hdr_t          hdr_i,
  input  logic              par_ok_i,
  input  logic [WORD_W-1:0] echo_i,
  output logic              take_o,
  output sra_okind_e        kind_o,
  output logic [WORD_W-1:0] word_o,
  output logic [SEL_W-1:0]  reg_sel_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_we_o,
  output logic              reg_re_o
);
  sra_phase_e        phase_q, phase_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              wr_q, wr_d, hold_q, hold_d;
  logic              acc;
  logic              upd_en;

  assign take_o = in_valid_i & ~cs_n_i;
  assign upd_en = cs_n_i | in_valid_i;

  always_comb begin
    phase_d = phase_q;
    addr_d  = addr_q;
    left_d  = left_q;
    sel_d   = sel_q;
    wr_d    = wr_q;
    hold_d  = hold_q;
    acc     = 1'b0;
    kind_o  = OK_ZERO;
    word_o  = in_word_i;
    if (cs_n_i) begin
      phase_d = PH_HDR;
    end else if (in_valid_i) begin
      unique case (phase_q)
        PH_HDR: begin
          if (hdr_i.ctl_n) begin
            phase_d = PH_DROP;
          end else begin
            kind_o = OK_WORD;
            word_o = echo_i;
            if (par_ok_i) begin
              phase_d = PH_BURST;
              addr_d  = hdr_i.addr;
              left_d  = {1'b0, hdr_i.cnt} + LEFT_W'(1);
              sel_d   = hdr_i.sel;
              wr_d    = hdr_i.wr;
              hold_d  = hdr_i.hold;
            end else begin
              phase_d = PH_DROP;
            end
          end
        end
        PH_BURST: begin
          if (left_q != '0) begin
            acc    = 1'b1;
            left_d = left_q - LEFT_W'(1);
            if (!hold_q) addr_d = addr_q + ADDR_W'(1);
            kind_o = wr_q ? OK_WORD : OK_READ;
          end else begin
            phase_d = PH_HDR;
          end
        end
        default: phase_d = PH_DROP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HDR;
      addr_q  <= '0;
      left_q  <= '0;
      sel_q   <= '0;
      wr_q    <= 1'b0;
      hold_q  <= 1'b0;
    end else if (upd_en) begin
      phase_q <= phase_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      sel_q   <= sel_d;
      wr_q    <= wr_d;
      hold_q  <= hold_d;
    end
  end

  assign reg_sel_o  = sel_q;
  assign reg_addr_o = addr_q;
  assign reg_we_o   = acc & wr_q;
  assign reg_re_o   = acc & ~wr_q;
endmodule

// File: rtl/sra_echo_pipe.sv
module sra_echo_pipe
  import sra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  sra_okind_e        kind_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] rdata_i,
  input  logic              hit_i,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_word_o
);
  logic              s1_v_q;
  sra_okind_e        s1_kind_q;
  logic [WORD_W-1:0] s1_word_q;
  logic [WORD_W-1:0] out_word_d;

  always_comb begin
    unique case (s1_kind_q)
      OK_READ: out_word_d = hit_i ? rdata_i : '0;
      OK_WORD: out_word_d = s1_word_q;
      default: out_word_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q      <= 1'b0;
      s1_kind_q   <= OK_ZERO;
      s1_word_q   <= '0;
      out_valid_o <= 1'b0;
      out_word_o  <= '0;
    end else begin
      s1_v_q      <= take_i;
      out_valid_o <= s1_v_q;
      if (take_i) begin
        s1_kind_q <= kind_i;
        s1_word_q <= word_i;
      end
      if (s1_v_q) out_word_o <= out_word_d;
    end
  end
endmodule

// File: rtl/sra_cmd_engine.sv
module sra_cmd_engine
  import sra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic [SEL_W-1:0]  reg_sel,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [WORD_W-1:0] reg_rdata,
  input  logic              reg_hit
);
  logic              rst_meta_n, rst_sync_n;
  sra_hdr_t          hdr;
  logic              par_ok;
  logic [WORD_W-1:0] echo_hdr;
  logic              take;
  sra_okind_e        kind;
  logic [WORD_W-1:0] slot_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  sra_hdr_dec u_dec (
    .word_i   (in_word),
    .hdr_o    (hdr),
    .par_ok_o (par_ok),
    .echo_o   (echo_hdr)
  );

  sra_burst_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cs_n_i     (cs_n),
    .in_valid_i (in_valid),
    .in_word_i  (in_word),
    .hdr_i      (hdr),
    .par_ok_i   (par_ok),
    .echo_i     (echo_hdr),
    .take_o     (take),
    .kind_o     (kind),
    .word_o     (slot_word),
    .reg_sel_o  (reg_sel),
    .reg_addr_o (reg_addr),
    .reg_we_o   (reg_we),
    .reg_re_o   (reg_re)
  );

  assign reg_wdata = in_word;

  sra_echo_pipe u_pipe (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .take_i      (take),
    .kind_i      (kind),
    .word_i      (slot_word),
    .rdata_i     (reg_rdata),
    .hit_i       (reg_hit),
    .out_valid_o (out_valid),
    .out_word_o  (out_word)
  );
endmodule

// File: rtl/sra_cmd_checker.sv
module sra_cmd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        in_valid,
  input logic        out_valid,
  input logic [31:0] out_word,
  input logic        reg_we,
  input logic        reg_re
);
  logic acc_in;
  assign acc_in = in_valid & ~cs_n;

  assert_out_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_in |=> ##1 out_valid);

  assert_out_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(acc_in, 2));

  assert_word_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_word));

  assert_access_needs_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || reg_re) |-> acc_in);

  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({reg_we, reg_re}) <= 1);
endmodule

bind sra_cmd_engine sra_cmd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cs_n      (cs_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_word  (out_word),
  .reg_we    (reg_we),
  .reg_re    (reg_re)
);

// File: tb/sra_cmd_engine_tb_top.sv
module sra_cmd_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, in_valid;
  logic [31:0] in_word;
  logic        out_valid;
  logic [31:0] out_word;
  logic [3:0]  reg_sel;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_we, reg_re;
  logic [31:0] reg_rdata;
  logic        reg_hit;

  always #2 clk = ~clk;  // 250 MHz

  sra_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_word(out_word), .reg_sel(reg_sel), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .reg_hit(reg_hit)
  );

  // register file model: map 1, addresses 0..15 implemented
  logic [31:0] mem [16];
  logic [31:0] shadow [16];
  function automatic bit impl(input logic [3:0] s, input logic [15:0] a);
    return (s == 4'd1) && (a < 16'd16);
  endfunction

  always @(posedge clk) begin
    if (reg_we && impl(reg_sel, reg_addr)) mem[reg_addr[3:0]] <= reg_wdata;
    if (reg_re) begin
      reg_hit   <= impl(reg_sel, reg_addr);
      reg_rdata <= impl(reg_sel, reg_addr) ? mem[reg_addr[3:0]] : 32'hDEAD_BEEF;
    end
  end

  int vectors = 0, errors = 0, we_cnt = 0, re_cnt = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    if (reg_we) we_cnt++;
    if (reg_re) re_cnt++;
    if (out_valid) begin
      vectors++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected output: actual %h expected none", out_word);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_word !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, out_word, e);
        end
      end
    end
  end

  task automatic check(input string t, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_hdr(input bit wr, input bit hold, input logic [3:0] s,
                                          input logic [15:0] a, input logic [6:0] c);
    logic [31:0] h;
    h = {1'b0, 1'b0, wr, hold, s, a, c, 1'b0};
    h[0] = ~(^h[31:1]);
    return h;
  endfunction

  function automatic logic [31:0] echo_of(input logic [31:0] h);
    logic [31:0] e;
    e = h;
    e[30] = ~(^h);
    e[0] = 1'b0;
    e[0] = ~(^e);
    return e;
  endfunction

  task automatic send(input logic [31:0] w, input bit expect_out,
                      input logic [31:0] e, input string t);
    if (expect_out) begin
      exp_q.push_back(e);
      tag_q.push_back(t);
    end
    @(negedge clk);
    in_word  = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sel_on();
    @(negedge clk); cs_n = 1'b0;
  endtask
  task automatic sel_off();
    @(negedge clk); cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_write(input logic [3:0] s, input logic [15:0] a, input bit hold,
                          input int n, input logic [31:0] base);
    logic [15:0] ad;
    ad = a;
    sel_on();
    send(mk_hdr(1'b1, hold, s, a, 7'(n - 1)), 1, echo_of(mk_hdr(1'b1, hold, s, a, 7'(n - 1))), "R4 header echo");
    for (int i = 0; i < n; i++) begin
      send(base + 32'(i), 1, base + 32'(i), "R5 write echo");
      if (impl(s, ad)) shadow[ad[3:0]] = base + 32'(i);
      if (!hold) ad = ad + 16'd1;
    end
    send(32'hFFFF_FFFF, 1, 32'h0, "R5 trailer zero");
    sel_off();
  endtask

  task automatic do_read(input logic [3:0] s, input logic [15:0] a, input bit hold, input int n);
    logic [15:0] ad;
    ad = a;
    sel_on();
    send(mk_hdr(1'b0, hold, s, a, 7'(n - 1)), 1, echo_of(mk_hdr(1'b0, hold, s, a, 7'(n - 1))), "R4 header echo");
    for (int i = 0; i < n; i++) begin
      send(32'h5A5A_0000 + 32'(i), 1, impl(s, ad) ? shadow[ad[3:0]] : 32'h0, "R6 read data");
      if (!hold) ad = ad + 16'd1;
    end
    send(32'h1234_5678, 1, 32'h0, "R6 trailer zero");
    sel_off();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int w0, r0;
    logic [31:0] h;
    for (int i = 0; i < 16; i++) begin mem[i] = 32'h0; shadow[i] = 32'h0; end
    reg_rdata = 32'h0; reg_hit = 1'b0;
    rst_n = 1'b0; cs_n = 1'b1; in_valid = 1'b0; in_word = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 out_valid after reset", int'(out_valid), 0);
    check("R10 out_word after reset", int'(out_word), 0);
    check("R10 strobes after reset", int'(reg_we | reg_re), 0);

    // R1 R3 R5 R6: incrementing write and read back
    w0 = we_cnt;
    do_write(4'd1, 16'd2, 1'b0, 4, 32'hA000_0010);
    check("R1 write count", we_cnt - w0, 4);
    do_read(4'd1, 16'd2, 1'b0, 4);

    // R3 hold address: last value wins at address 5, address 6 untouched
    do_write(4'd1, 16'd5, 1'b1, 3, 32'hB000_0000);
    do_read(4'd1, 16'd5, 1'b0, 2);

    // R6 read across the end of the implemented range, and another map
    do_write(4'd2, 16'd3, 1'b0, 2, 32'hC000_0000);
    do_read(4'd1, 16'd14, 1'b0, 4);
    do_read(4'd2, 16'd3, 1'b0, 2);

    // R2 count extremes
    w0 = we_cnt;
    do_write(4'd1, 16'd9, 1'b0, 1, 32'hD000_0009);
    check("R2 single access", we_cnt - w0, 1);
    w0 = we_cnt;
    do_write(4'd1, 16'd0, 1'b1, 128, 32'hE000_0000);
    check("R2 128 writes", we_cnt - w0, 128);
    r0 = re_cnt;
    do_read(4'd1, 16'd0, 1'b1, 128);
    check("R2 128 reads", re_cnt - r0, 128);

    // R4 host sets bit 30 on a good header: echo clears it
    sel_on();
    h = mk_hdr(1'b0, 1'b0, 4'd1, 16'd9, 7'd0);
    h[30] = 1'b1; h[0] = ~h[0];
    send(h, 1, {h[31], 1'b0, h[29:1], ~h[0]}, "R4 ignored bad bit");
    send(32'h0, 1, shadow[9], "R6 read data");
    send(32'h0, 1, 32'h0, "R6 trailer zero");
    sel_off();

    // R7 bad parity: no access, zeros until release
    w0 = we_cnt;
    sel_on();
    h = mk_hdr(1'b1, 1'b0, 4'd1, 16'd2, 7'd1);
    h[0] = ~h[0];
    send(h, 1, echo_of(h), "R7 bad header echo");
    check("R7 bad flag set", int'(echo_of(h) >> 30) & 1, 1);
    send(32'h7777_7777, 1, 32'h0, "R7 dropped word");
    send(32'h8888_8888, 1, 32'h0, "R7 dropped word");
    send(32'h9999_9999, 1, 32'h0, "R7 dropped word");
    sel_off();
    check("R7 no write", we_cnt - w0, 0);
    do_read(4'd1, 16'd2, 1'b0, 2);

    // R8 data-type header is not a command
    w0 = we_cnt; r0 = re_cnt;
    sel_on();
    send(32'h8000_0001 | mk_hdr(1'b1, 1'b0, 4'd1, 16'd2, 7'd0), 1, 32'h0, "R8 non-command");
    send(32'h4444_4444, 1, 32'h0, "R8 dropped word");
    send(32'h5555_5555, 1, 32'h0, "R8 dropped word");
    sel_off();
    check("R8 no access", (we_cnt - w0) + (re_cnt - r0), 0);

    // R9 abort mid burst, then a pulse while deselected
    w0 = we_cnt;
    sel_on();
    send(mk_hdr(1'b1, 1'b0, 4'd1, 16'd8, 7'd3), 1, echo_of(mk_hdr(1'b1, 1'b0, 4'd1, 16'd8, 7'd3)), "R9 header echo");
    send(32'hF000_0008, 1, 32'hF000_0008, "R9 first word");
    shadow[8] = 32'hF000_0008;
    send(32'hF000_0009, 1, 32'hF000_0009, "R9 second word");
    shadow[9] = 32'hF000_0009;
    @(negedge clk);
    cs_n = 1'b1; in_word = 32'hF000_000A; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 access stops", we_cnt - w0, 2);
    check("R9 no output while deselected", exp_q.size(), 0);
    do_read(4'd1, 16'd8, 1'b0, 4);

    repeat (10) @(negedge clk);
    check("R10 all outputs seen", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule